// File: doc/BRIEF.md
# Dual-Channel Indirect Register Access Controller

This block is the host-facing register front end of a two-channel serial controller. The host sees only a narrow 8-bit bus. For each channel it can reach a control port and a data port. Registers are never addressed directly. A control-port write, made while the channel's pointer is zero, loads a register number and can also carry a command. The next control access, read or write, reaches the selected register. The pointer then falls back to zero.

The block stores each channel's write registers and keeps two registers that both channels share. It also keeps a hidden alternate register that sits behind register 7. Read registers come from a multiplexer over the stored values and the status inputs. The serial engines and the interrupt logic are not part of this block: they supply status bytes and pending bits as inputs. They receive the register contents, the command strobes and the transmit-byte pushes as outputs.

Top module: `sccr_access_top`

## Requirements
- R1: A control write to a channel whose pointer is 0 loads that channel's pointer from bits 2:0 of the written byte. The next control access on that channel reaches the register with that number.
- R2: When bits 5:3 of a pointer-loading write equal 001, the pointer becomes 8 plus bits 2:0, so registers 8 to 15 can be reached.
- R3: A control read or write on a channel whose pointer is not 0 returns that pointer to 0. The following control access is again a pointer write. A control read with pointer 0 returns status byte 0 and leaves the pointer at 0.
- R4: In a pointer-loading write, bits 5:3 values 2 to 7 raise bit k of `cmd_stb` for that channel, where k is the value, for exactly one cycle, in the cycle after the write. Values 0 and 1 raise no strobe.
- R5: In a pointer-loading write, bits 7:6 values 1, 2 and 3 raise bit k of `crc_stb` for that channel for one cycle, in the cycle after the write. Here 1 resets the receive check, 2 resets the transmit generator and 3 clears the underrun/end-of-message latch. Value 0 raises nothing.
- R6: Registers 2 and 9 are one storage location each, shared by both channels. A write through either channel shows up at both channels' `wreg_o` entries and reads of register 2.
- R7: Reading register 3 on channel A (`bus_ch`=0) returns {2'b00, pend_a[2:0], pend_b[2:0]}, each group ordered receive, transmit, status from MSB down. On channel B it returns 0x00.
- R8: While bit 0 of a channel's register 15 is 1, writes to register 7 on that channel go to the alternate register (`wreg_alt7`) and leave register 7 unchanged. Register 14 reads the alternate register. While the bit is 0, register 7 is written normally.
- R9: Reading register 15 returns written register 15 with bits 2 and 0 cleared. Registers 12 and 13 read back the stored low and high time-constant bytes.
- R10: Synchronous reset clears both pointers, every stored register, the alternate registers and all strobes. Reads of registers 4 to 9 and 11 return 0x00. Registers 0 and 8 are not stored.
- R11: A data-port write raises `tx_push` for that channel for one cycle, in the cycle after the write, with `tx_byte` equal to the data. A data-port read returns `rx_byte` for that channel. Data-port accesses never change a pointer.
- R12: Control reads of registers 0, 1 and 10 return that channel's `st_rr0`, `st_rr1` and `st_rr10` inputs. `bus_rdata` is 0x00 whenever no read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_ch | input | 1 | Channel select, 0 = A, 1 = B |
| bus_dport | input | 1 | 1 = data port, 0 = control port |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, combinational |
| st_rr0 | input | 2x8 | Per-channel buffer/external status byte |
| st_rr1 | input | 2x8 | Per-channel receive condition status byte |
| st_rr10 | input | 2x8 | Per-channel miscellaneous status byte |
| pend_a | input | 3 | Channel A pending: receive, transmit, status |
| pend_b | input | 3 | Channel B pending: receive, transmit, status |
| rx_byte | input | 2x8 | Per-channel received byte |
| tx_push | output | 2 | Per-channel transmit byte strobe |
| tx_byte | output | 8 | Byte written through a data port |
| cmd_stb | output | 2x8 | Per-channel command strobes, bit = command code |
| crc_stb | output | 2x4 | Per-channel reset-modifier strobes, bit = code |
| wreg_o | output | 2x16x8 | Register contents per channel and index |
| wreg_alt7 | output | 2x8 | Per-channel alternate register behind index 7 |

## Verification
The assertions assume that only one access happens per cycle and that `bus_ch` holds a valid channel whenever `bus_en` is high. They also assume that `bus_wr`, `bus_dport` and `bus_wdata` are stable for the whole cycle in which `bus_en` is high. The stimulus keeps to this by driving every access from a single task that changes inputs only at the falling edge and keeps one access per cycle. Between accesses it drops `bus_en` for at least one cycle, so each strobe can be seen rising and falling on its own. The status, pending and receive inputs are changed only while `bus_en` is low.

// File: rtl/sccr_pkg.sv
package sccr_pkg;

    localparam int NCH   = 2;
    localparam int DW    = 8;
    localparam int NREG  = 16;
    localparam int PW    = $clog2(NREG);
    localparam int NCMD  = 8;
    localparam int NRST  = 4;
    localparam int HIGH_BANK = NREG / 2;
    localparam int ALT_EN_BIT = 0;

    typedef logic [DW-1:0]   byte_t;
    typedef logic [PW-1:0]   ptr_t;
    typedef logic [NCMD-1:0] cmd_vec_t;
    typedef logic [NRST-1:0] rst_vec_t;
    typedef logic [NCH-1:0][NREG-1:0][DW-1:0] regfile_t;
    typedef logic [NCH-1:0][DW-1:0] chan_bytes_t;

    typedef enum logic [2:0] {
        CMD_NONE    = 3'd0,
        CMD_UPPER   = 3'd1,
        CMD_CLR_EXT = 3'd2,
        CMD_ABORT   = 3'd3,
        CMD_ARM_RX  = 3'd4,
        CMD_CLR_TXI = 3'd5,
        CMD_CLR_ERR = 3'd6,
        CMD_CLR_IUS = 3'd7
    } cmd_e;

    typedef struct packed {
        logic [1:0] rst_code;
        cmd_e       cmd;
        logic [2:0] reg_lo;
    } ctl_word_t;

    localparam ptr_t IDX_PTR   = ptr_t'(0);
    localparam ptr_t IDX_ST1   = ptr_t'(1);
    localparam ptr_t IDX_VEC   = ptr_t'(2);
    localparam ptr_t IDX_PEND  = ptr_t'(3);
    localparam ptr_t IDX_SEL7  = ptr_t'(7);
    localparam ptr_t IDX_TXBUF = ptr_t'(8);
    localparam ptr_t IDX_MIC   = ptr_t'(9);
    localparam ptr_t IDX_ST10  = ptr_t'(10);
    localparam ptr_t IDX_TCLO  = ptr_t'(12);
    localparam ptr_t IDX_TCHI  = ptr_t'(13);
    localparam ptr_t IDX_ALTRD = ptr_t'(14);
    localparam ptr_t IDX_EXT   = ptr_t'(15);

    localparam byte_t EXT_READ_MASK = 8'hFA;

    function automatic ptr_t next_pointer(input ctl_word_t cw);
        ptr_t base;
        base = (cw.cmd == CMD_UPPER) ? ptr_t'(HIGH_BANK) : '0;
        return base + ptr_t'(cw.reg_lo);
    endfunction

endpackage

// File: rtl/sccr_ptr_ctl.sv
module sccr_ptr_ctl
    import sccr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sel,
    input  logic     wr,
    input  byte_t    wdata,
    output ptr_t     ptr,
    output cmd_vec_t cmd_stb,
    output rst_vec_t crc_stb
);
    ctl_word_t cw;
    assign cw = ctl_word_t'(wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr     <= '0;
            cmd_stb <= '0;
            crc_stb <= '0;
        end else begin
            cmd_stb <= '0;
            crc_stb <= '0;
            if (sel && wr && (ptr == IDX_PTR)) begin
                ptr <= next_pointer(cw);
                if (cw.cmd != CMD_NONE && cw.cmd != CMD_UPPER)
                    cmd_stb[cw.cmd] <= 1'b1;
                if (cw.rst_code != 2'b00)
                    crc_stb[cw.rst_code] <= 1'b1;
            end else if (sel && (ptr != IDX_PTR)) begin
                ptr <= '0;
            end
        end
    end
endmodule

// File: rtl/sccr_reg_bank.sv
module sccr_reg_bank
    import sccr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic        ch,
    input  ptr_t        idx,
    input  byte_t       wdata,
    output regfile_t    wreg,
    output chan_bytes_t alt7
);
    regfile_t priv;
    byte_t    sh_vec;
    byte_t    sh_mic;

    always_ff @(posedge clk) begin
        if (rst) begin
            priv   <= '0;
            sh_vec <= '0;
            sh_mic <= '0;
            alt7   <= '0;
        end else if (we) begin
            if (idx == IDX_VEC)
                sh_vec <= wdata;
            else if (idx == IDX_MIC)
                sh_mic <= wdata;
            else if (idx == IDX_SEL7 && priv[ch][IDX_EXT][ALT_EN_BIT])
                alt7[ch] <= wdata;
            else if (idx != IDX_PTR && idx != IDX_TXBUF)
                priv[ch][idx] <= wdata;
        end
    end

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            for (int r = 0; r < NREG; r++) begin
                if (ptr_t'(r) == IDX_VEC)
                    wreg[c][r] = sh_vec;
                else if (ptr_t'(r) == IDX_MIC)
                    wreg[c][r] = sh_mic;
                else if (ptr_t'(r) == IDX_PTR || ptr_t'(r) == IDX_TXBUF)
                    wreg[c][r] = '0;
                else
                    wreg[c][r] = priv[c][r];
            end
        end
    end
endmodule

// File: rtl/sccr_rd_mux.sv
module sccr_rd_mux
    import sccr_pkg::*;
(
    input  logic        ch,
    input  ptr_t        ptr,
    input  regfile_t    wreg,
    input  chan_bytes_t alt7,
    input  chan_bytes_t st_rr0,
    input  chan_bytes_t st_rr1,
    input  chan_bytes_t st_rr10,
    input  logic [2:0]  pend_a,
    input  logic [2:0]  pend_b,
    output byte_t       rd
);
    always_comb begin
        unique case (ptr)
            IDX_PTR:   rd = st_rr0[ch];
            IDX_ST1:   rd = st_rr1[ch];
            IDX_PEND:  rd = (ch == 1'b0) ? {2'b00, pend_a, pend_b} : '0;
            IDX_ST10:  rd = st_rr10[ch];
            IDX_VEC,
            IDX_TCLO,
            IDX_TCHI:  rd = wreg[ch][ptr];
            IDX_ALTRD: rd = alt7[ch];
            IDX_EXT:   rd = wreg[ch][ptr] & EXT_READ_MASK;
            default:   rd = '0;
        endcase
    end
endmodule

// File: rtl/sccr_access_top.sv
module sccr_access_top
    import sccr_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      bus_en,
    input  logic                      bus_wr,
    input  logic                      bus_ch,
    input  logic                      bus_dport,
    input  logic [7:0]                bus_wdata,
    output logic [7:0]                bus_rdata,
    input  logic [1:0][7:0]           st_rr0,
    input  logic [1:0][7:0]           st_rr1,
    input  logic [1:0][7:0]           st_rr10,
    input  logic [2:0]                pend_a,
    input  logic [2:0]                pend_b,
    input  logic [1:0][7:0]           rx_byte,
    output logic [1:0]                tx_push,
    output logic [7:0]                tx_byte,
    output logic [1:0][7:0]           cmd_stb,
    output logic [1:0][3:0]           crc_stb,
    output logic [1:0][15:0][7:0]     wreg_o,
    output logic [1:0][7:0]           wreg_alt7
);
    logic [NCH-1:0][PW-1:0] ptr_q;
    logic [NCH-1:0]         ctl_sel;
    logic                   bank_we;
    byte_t                  mux_rd;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        assign ctl_sel[c] = bus_en && !bus_dport && (bus_ch == c[0]);
        sccr_ptr_ctl u_ptr (
            .clk     (clk),
            .rst     (rst),
            .sel     (ctl_sel[c]),
            .wr      (bus_wr),
            .wdata   (bus_wdata),
            .ptr     (ptr_q[c]),
            .cmd_stb (cmd_stb[c]),
            .crc_stb (crc_stb[c])
        );
    end

    assign bank_we = bus_en && bus_wr && !bus_dport && (ptr_q[bus_ch] != IDX_PTR);

    sccr_reg_bank u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (bank_we),
        .ch    (bus_ch),
        .idx   (ptr_q[bus_ch]),
        .wdata (bus_wdata),
        .wreg  (wreg_o),
        .alt7  (wreg_alt7)
    );

    sccr_rd_mux u_mux (
        .ch      (bus_ch),
        .ptr     (ptr_q[bus_ch]),
        .wreg    (wreg_o),
        .alt7    (wreg_alt7),
        .st_rr0  (st_rr0),
        .st_rr1  (st_rr1),
        .st_rr10 (st_rr10),
        .pend_a  (pend_a),
        .pend_b  (pend_b),
        .rd      (mux_rd)
    );

    always_comb begin
        if (bus_en && !bus_wr)
            bus_rdata = bus_dport ? rx_byte[bus_ch] : mux_rd;
        else
            bus_rdata = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_push <= '0;
            tx_byte <= '0;
        end else begin
            tx_push <= '0;
            if (bus_en && bus_dport && bus_wr) begin
                tx_push[bus_ch] <= 1'b1;
                tx_byte         <= bus_wdata;
            end
        end
    end
endmodule

// File: rtl/sccr_access_chk.sv
module sccr_access_chk
    import sccr_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   bus_en,
    input logic                   bus_wr,
    input logic                   bus_ch,
    input logic                   bus_dport,
    input logic [7:0]             bus_wdata,
    input logic [7:0]             bus_rdata,
    input logic [1:0][7:0]        cmd_stb,
    input logic [1:0][3:0]        crc_stb,
    input logic [1:0]             tx_push,
    input logic [7:0]             mic_a,
    input logic [7:0]             mic_b,
    input logic [NCH-1:0][PW-1:0] ptr_q
);
    logic ctl_rd;
    assign ctl_rd = bus_en && !bus_wr && !bus_dport;

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R3: an access through a non-zero pointer sends it back to 0
        p_ptr_return_r3: assert property (@(posedge clk) disable iff (rst)
            (bus_en && !bus_dport && bus_ch == c[0] && ptr_q[c] != '0) |=> (ptr_q[c] == '0));

        // R4: at most one command strobe, never for codes 0 or 1
        p_cmd_onehot_r4: assert property (@(posedge clk) disable iff (rst)
            $onehot0(cmd_stb[c]) && (cmd_stb[c][1:0] == 2'b00));

        // R4: a strobe needs a pointer-loading write on that channel one cycle earlier
        p_cmd_cause_r4: assert property (@(posedge clk) disable iff (rst)
            (|cmd_stb[c]) |-> $past(bus_en && bus_wr && !bus_dport && bus_ch == c[0] && ptr_q[c] == '0));

        // R5: reset-modifier strobes follow the same cause rule
        p_crc_cause_r5: assert property (@(posedge clk) disable iff (rst)
            (|crc_stb[c]) |-> $past(bus_en && bus_wr && !bus_dport && bus_ch == c[0] && ptr_q[c] == '0));

        // R11: a data-port write leaves the pointer alone
        p_dport_ptr_r11: assert property (@(posedge clk) disable iff (rst)
            (bus_en && bus_dport) |=> $stable(ptr_q[c]));
    end

    // R6: a write to index 9 through either channel lands in the shared register
    p_shared_mic_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_en && bus_wr && !bus_dport && ptr_q[bus_ch] == 4'd9)
        |=> (mic_a == $past(bus_wdata)) && (mic_b == $past(bus_wdata)));

    // R7: channel B has no pending register
    p_pend_b_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (ctl_rd && bus_ch == 1'b1 && ptr_q[1] == 4'd3) |-> (bus_rdata == 8'h00));

    // R9: register 15 read hides bits 2 and 0
    p_ext_mask_r9: assert property (@(posedge clk) disable iff (rst)
        (ctl_rd && ptr_q[bus_ch] == 4'd15) |-> (bus_rdata[2] == 1'b0 && bus_rdata[0] == 1'b0));

    // R10: unimplemented read indices return zero
    p_unimpl_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (ctl_rd && ((ptr_q[bus_ch] >= 4'd4 && ptr_q[bus_ch] <= 4'd9) || ptr_q[bus_ch] == 4'd11))
        |-> (bus_rdata == 8'h00));

    // R11: one transmit push at a time
    p_tx_onehot_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tx_push));
endmodule

bind sccr_access_top sccr_access_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_en    (bus_en),
    .bus_wr    (bus_wr),
    .bus_ch    (bus_ch),
    .bus_dport (bus_dport),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cmd_stb   (cmd_stb),
    .crc_stb   (crc_stb),
    .tx_push   (tx_push),
    .mic_a     (wreg_o[0][9]),
    .mic_b     (wreg_o[1][9]),
    .ptr_q     (ptr_q)
);

// File: tb/tb_sccr_access_top.sv
module tb_sccr_access_top;

    logic clk = 1'b0;
    logic rst;
    logic bus_en, bus_wr, bus_ch, bus_dport;
    logic [7:0] bus_wdata, bus_rdata;
    logic [1:0][7:0] st_rr0, st_rr1, st_rr10, rx_byte;
    logic [2:0] pend_a, pend_b;
    logic [1:0] tx_push;
    logic [7:0] tx_byte;
    logic [1:0][7:0] cmd_stb;
    logic [1:0][3:0] crc_stb;
    logic [1:0][15:0][7:0] wreg_o;
    logic [1:0][7:0] wreg_alt7;

    int checks = 0;
    int failures = 0;

    // behavioural reference state
    logic [7:0] m_wr [2][16];
    logic [7:0] m_alt [2];
    int m_ptr [2];

    always #4ns clk = ~clk;

    sccr_access_top dut (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_wr(bus_wr), .bus_ch(bus_ch),
        .bus_dport(bus_dport), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .st_rr0(st_rr0), .st_rr1(st_rr1), .st_rr10(st_rr10),
        .pend_a(pend_a), .pend_b(pend_b), .rx_byte(rx_byte),
        .tx_push(tx_push), .tx_byte(tx_byte), .cmd_stb(cmd_stb), .crc_stb(crc_stb),
        .wreg_o(wreg_o), .wreg_alt7(wreg_alt7)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            for (int r = 0; r < 16; r++) m_wr[c][r] = 8'h00;
            m_alt[c] = 8'h00;
            m_ptr[c] = 0;
        end
    endtask

    function automatic logic [7:0] model_rd(input int ch, input int p);
        case (p)
            0:  return st_rr0[ch];
            1:  return st_rr1[ch];
            2:  return m_wr[ch][2];
            3:  return (ch == 0) ? {2'b00, pend_a, pend_b} : 8'h00;
            10: return st_rr10[ch];
            12: return m_wr[ch][12];
            13: return m_wr[ch][13];
            14: return m_alt[ch];
            15: return m_wr[ch][15] & 8'hFA;
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_write(input int ch, input int idx, input logic [7:0] d);
        if (idx == 2 || idx == 9) begin
            m_wr[0][idx] = d;
            m_wr[1][idx] = d;
        end else if (idx == 7 && m_wr[ch][15][0]) begin
            m_alt[ch] = d;
        end else if (idx != 0 && idx != 8) begin
            m_wr[ch][idx] = d;
        end
    endtask

    task automatic chk_regs(input string tag);
        logic [31:0] a, e;
        a = 0; e = 0;
        for (int c = 1; c >= 0; c--) begin
            if (wreg_alt7[c] !== m_alt[c]) begin a = {8'hA7, 8'(c), 8'h00, wreg_alt7[c]}; e = {8'hA7, 8'(c), 8'h00, m_alt[c]}; end
            for (int r = 15; r >= 0; r--)
                if (wreg_o[c][r] !== m_wr[c][r]) begin
                    a = {8'(c), 8'(r), 8'h00, wreg_o[c][r]};
                    e = {8'(c), 8'(r), 8'h00, m_wr[c][r]};
                end
        end
        chk(tag, a, e);
    endtask

    // One access; checks read data, then the strobes and stored registers, then that strobes drop.
    task automatic acc(input int ch, input bit dp, input bit wr, input logic [7:0] d, input string tag);
        logic [1:0][7:0] e_cmd;
        logic [1:0][3:0] e_crc;
        logic [1:0] e_tx;
        e_cmd = '0; e_crc = '0; e_tx = '0;
        @(negedge clk);
        bus_en = 1'b1; bus_wr = wr; bus_ch = ch[0]; bus_dport = dp; bus_wdata = d;
        #1ns;
        if (!wr) chk({tag, " rdata"}, {24'h0, bus_rdata}, {24'h0, dp ? rx_byte[ch] : model_rd(ch, m_ptr[ch])});
        if (dp) begin
            if (wr) e_tx[ch] = 1'b1;
        end else if (m_ptr[ch] == 0) begin
            if (wr) begin
                if (d[5:3] >= 3'd2) e_cmd[ch][d[5:3]] = 1'b1;
                if (d[7:6] != 2'b00) e_crc[ch][d[7:6]] = 1'b1;
                m_ptr[ch] = ((d[5:3] == 3'd1) ? 8 : 0) + int'(d[2:0]);
            end
        end else begin
            if (wr) model_write(ch, m_ptr[ch], d);
            m_ptr[ch] = 0;
        end
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0; bus_dport = 1'b0; bus_wdata = 8'h00;
        chk({tag, " cmd_stb R4"}, {16'h0, cmd_stb}, {16'h0, e_cmd});
        chk({tag, " crc_stb R5"}, {24'h0, crc_stb}, {24'h0, e_crc});
        chk({tag, " tx_push R11"}, {30'h0, tx_push}, {30'h0, e_tx});
        if (e_tx != 2'b00) chk({tag, " tx_byte R11"}, {24'h0, tx_byte}, {24'h0, d});
        chk_regs({tag, " regs"});
        @(negedge clk);
        chk({tag, " strobes one cycle R4 R5"}, {6'h0, tx_push, crc_stb, cmd_stb}, 32'h0);
    endtask

    task automatic wr_reg(input int ch, input int idx, input logic [7:0] d, input string tag);
        acc(ch, 0, 1, (idx >= 8) ? (8'h08 | 8'(idx & 7)) : 8'(idx), tag);
        acc(ch, 0, 1, d, tag);
    endtask

    task automatic rd_reg(input int ch, input int idx, input string tag);
        acc(ch, 0, 1, (idx >= 8) ? (8'h08 | 8'(idx & 7)) : 8'(idx), tag);
        acc(ch, 0, 0, 8'h00, tag);
    endtask

    initial begin
        #800us;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1;
        bus_en = 1'b0; bus_wr = 1'b0; bus_ch = 1'b0; bus_dport = 1'b0; bus_wdata = 8'h00;
        st_rr0 = {8'h4C, 8'h25}; st_rr1 = {8'h81, 8'h10}; st_rr10 = {8'h12, 8'h90};
        rx_byte = {8'hB7, 8'h3E}; pend_a = 3'b101; pend_b = 3'b010;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10: reset state
        chk_regs("R10 reset regs");
        chk("R10 reset strobes", {6'h0, tx_push, crc_stb, cmd_stb}, 32'h0);
        acc(0, 0, 0, 8'h00, "R12 R3 RR0 chA ptr0");
        acc(1, 0, 0, 8'h00, "R12 RR0 chB");

        // R1 / R3: pointer load, write, pointer back to 0
        wr_reg(0, 5, 8'h3C, "R1 write WR5 A");
        wr_reg(1, 4, 8'hC5, "R1 write WR4 B");
        rd_reg(1, 1, "R12 RR1 B");
        acc(1, 0, 0, 8'h00, "R3 ptr back to 0 after read");
        rd_reg(0, 10, "R12 RR10 A");

        // R2 / R9: upper bank
        wr_reg(0, 12, 8'h34, "R2 write WR12 A");
        wr_reg(0, 13, 8'h9D, "R2 write WR13 A");
        rd_reg(0, 12, "R9 RR12 A");
        rd_reg(0, 13, "R9 RR13 A");
        rd_reg(1, 12, "R9 RR12 B untouched");

        // R6: shared registers
        wr_reg(0, 2, 8'h5A, "R6 write WR2 via A");
        rd_reg(1, 2, "R6 RR2 via B");
        wr_reg(1, 9, 8'h81, "R6 write WR9 via B");
        wr_reg(0, 9, 8'h18, "R6 write WR9 via A");

        // R7: pending register
        rd_reg(0, 3, "R7 RR3 A");
        pend_a = 3'b011; pend_b = 3'b100;
        rd_reg(0, 3, "R7 RR3 A new pattern");
        rd_reg(1, 3, "R7 RR3 B zero");

        // R8: alternate register 7
        wr_reg(0, 7, 8'h11, "R8 WR7 A normal");
        wr_reg(0, 15, 8'hFF, "R8 WR15 A enable alt");
        rd_reg(0, 15, "R9 RR15 A mask");
        wr_reg(0, 7, 8'h77, "R8 WR7 A to alt");
        rd_reg(0, 14, "R8 RR14 A alt");
        wr_reg(1, 7, 8'h66, "R8 WR7 B normal");
        rd_reg(1, 14, "R8 RR14 B zero");
        wr_reg(0, 15, 8'h24, "R8 WR15 A disable alt");
        wr_reg(0, 7, 8'h99, "R8 WR7 A normal again");
        rd_reg(0, 15, "R9 RR15 A pattern 2");

        // R4 / R5: every command and reset code
        for (int code = 0; code < 8; code++) begin
            acc(code & 1, 0, 1, 8'((code & 3) << 6) | 8'(code << 3), "R4 R5 command sweep");
            if (m_ptr[code & 1] != 0) acc(code & 1, 0, 0, 8'h00, "R10 R3 after point high");
        end

        // R10: unimplemented reads
        for (int r = 4; r <= 11; r++)
            if (r != 10) rd_reg(0, r, "R10 unimplemented read");

        // R11: data port does not disturb the pointer
        acc(0, 0, 1, 8'h0A, "R11 set ptr 10");
        acc(0, 1, 1, 8'hA5, "R11 data write A");
        acc(1, 1, 1, 8'h5B, "R11 data write B");
        acc(0, 1, 0, 8'h00, "R11 data read A");
        acc(0, 0, 0, 8'h00, "R11 ptr kept RR10");
        acc(1, 1, 0, 8'h00, "R11 data read B");

        // R10: reset mid-run
        acc(1, 0, 1, 8'h0D, "R10 leave ptr set");
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        model_reset();
        chk_regs("R10 reset clears regs");
        acc(1, 0, 0, 8'h00, "R10 R12 ptr cleared RR0");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule